// File: doc/BRIEF.md
# Bounded Failure Recovery Escalator

This block sits beside a bridge data path and watches the outcome of every transaction it finishes. Each completion arrives as a one-cycle done strobe with a fail flag. A run of failures of programmable length starts a recovery step, so retries can never repeat without limit. The first step asks for a soft reset. If the failures come back before any transaction succeeds, the next step asks for a hard reset. If they come back after the hard reset, the block raises a sticky fault and stops escalating.

A watchdog covers a data path that hangs. If no completion and no kick arrive for a programmable number of cycles, the watchdog starts the same recovery ladder. Each reset request is a pulse of programmable width, followed by a settle interval of programmable length. A detach request is held for the whole window (pulse plus settle) so that the host drops the device rather than keeping a stale instance of it. While the window is open, completions are ignored.

The cause of the most recent reset is latched. Separate counters record soft resets, hard resets and watchdog-started resets for logging. All knobs are plain input ports, so whatever drives them can also read them back.

Top module: `recovery_escalator`

## Requirements
- R1: After reset, both reset requests, the detach request and the fault flag are low, the reason code is 2'b00, and the failure run and all three trigger counters are zero.
- R2: The done strobe that carries the N-th failure in a row, with N equal to `cfg_fail_limit` (a value of 0 acts as 1), starts a recovery request on the very next cycle. A shorter run starts nothing.
- R3: A successful completion (done with fail low) clears the failure run and the escalation level, so the next recovery is a soft reset again.
- R4: A recovery with no success since the previous soft reset raises `hard_rst_req` instead of `soft_rst_req`.
- R5: Each request stays high for exactly `cfg_pulse_width` cycles (0 acts as 1), and only one of the two requests is high at any time.
- R6: `detach_req` rises together with the request and stays high for pulse width plus `cfg_settle_time` cycles.
- R7: Completions that arrive while `detach_req` is high are ignored. They neither count as failures nor clear anything, and the failure run reads 0 once the window ends.
- R8: A recovery that would follow a hard reset with no success in between sets `fault_flag` instead. The flag stays set, and no request or detach is issued until `rst_n` is asserted.
- R9: With `cfg_wd_timeout` equal to T (nonzero), T consecutive cycles without a done strobe or `wd_kick` start a recovery on the next cycle. A value of 0 turns the watchdog off.
- R10: `reset_reason` is latched at each recovery and holds until the next one: 2'b01 means the failure threshold was reached, 2'b10 means the watchdog expired.
- R11: `cnt_soft` and `cnt_hard` count the soft and hard requests issued, and `cnt_wd` counts the recoveries started by the watchdog. All three saturate at their maximum.
- R12: `fail_run` shows the current number of consecutive failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_done | input | 1 | One-cycle strobe: a transaction has completed |
| txn_fail | input | 1 | Qualifies `txn_done`: high means the transaction failed |
| wd_kick | input | 1 | Restarts the watchdog |
| cfg_fail_limit | input | FAIL_W | Number of consecutive failures that starts a recovery |
| cfg_wd_timeout | input | TMR_W | Watchdog timeout in cycles; 0 turns it off |
| cfg_pulse_width | input | PW_W | Reset request width in cycles |
| cfg_settle_time | input | TMR_W | Settle cycles after each request |
| soft_rst_req | output | 1 | Soft reset request pulse |
| hard_rst_req | output | 1 | Hard reset request pulse |
| detach_req | output | 1 | Detach request, held for the recovery window |
| fault_flag | output | 1 | Sticky fault: escalation has been exhausted |
| reset_reason | output | 2 | Latched cause of the last recovery |
| fail_run | output | FAIL_W | Current consecutive failure count |
| cnt_soft | output | CNT_W | Soft resets issued |
| cnt_hard | output | CNT_W | Hard resets issued |
| cnt_wd | output | CNT_W | Recoveries started by the watchdog |

## Verification
Some rules are checked on every cycle. Once the fault flag is set, it stays set and no detach is issued. A hard request never rises before a soft one has been counted. Every request rise advances its counter. Every window opens with a nonzero reason code. The failure run is zero throughout the window. Other behaviour only shows up across whole scenarios, and the bench's sequences demonstrate it: the exact cycle on which a threshold or a timeout fires, the soft-then-hard-then-fault ladder, a success resetting the ladder, and failures that land inside a window being ignored.

// File: rtl/recovery_escalator.sv
module recovery_escalator #(
  parameter int FAIL_W = 8,
  parameter int TMR_W  = 16,
  parameter int PW_W   = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_done,
  input  logic              txn_fail,
  input  logic              wd_kick,
  input  logic [FAIL_W-1:0] cfg_fail_limit,
  input  logic [TMR_W-1:0]  cfg_wd_timeout,
  input  logic [PW_W-1:0]   cfg_pulse_width,
  input  logic [TMR_W-1:0]  cfg_settle_time,
  output logic              soft_rst_req,
  output logic              hard_rst_req,
  output logic              detach_req,
  output logic              fault_flag,
  output logic [1:0]        reset_reason,
  output logic [FAIL_W-1:0] fail_run,
  output logic [CNT_W-1:0]  cnt_soft,
  output logic [CNT_W-1:0]  cnt_hard,
  output logic [CNT_W-1:0]  cnt_wd
);

  localparam logic [FAIL_W-1:0] FAIL_MAX = {FAIL_W{1'b1}};
  localparam logic [TMR_W-1:0]  TMR_MAX  = {TMR_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [1:0] WHY_FAIL = 2'b01;
  localparam logic [1:0] WHY_WDOG = 2'b10;

  typedef enum logic [1:0] {S_RUN, S_PULSE, S_SETTLE} st_t;

  st_t               st;
  logic [1:0]        lvl;
  logic              hard_sel;
  logic [PW_W-1:0]   pcnt;
  logic [TMR_W-1:0]  tcnt;
  logic [TMR_W-1:0]  wd_cnt;
  logic [FAIL_W-1:0] fail_cnt;

  wire              running  = (st == S_RUN);
  wire [FAIL_W-1:0] lim_eff  = (cfg_fail_limit == '0) ? FAIL_W'(1) : cfg_fail_limit;
  wire [PW_W-1:0]   pw_eff   = (cfg_pulse_width == '0) ? PW_W'(1) : cfg_pulse_width;
  wire              ok_done  = running && txn_done && !txn_fail;
  wire              bad_done = running && txn_done && txn_fail;
  wire              wd_act   = txn_done || wd_kick;
  wire              wd_on    = (cfg_wd_timeout != '0);
  wire              fail_hit = bad_done &&
                      (({1'b0, fail_cnt} + (FAIL_W+1)'(1)) >= {1'b0, lim_eff});
  wire              wd_hit   = running && wd_on && !wd_act &&
                      (wd_cnt >= cfg_wd_timeout - TMR_W'(1));
  wire              trig     = running && !fault_flag && (fail_hit || wd_hit);

  assign soft_rst_req = (st == S_PULSE) && !hard_sel;
  assign hard_rst_req = (st == S_PULSE) && hard_sel;
  assign detach_req   = !running;
  assign fail_run     = fail_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_RUN;
      lvl          <= 2'd0;
      hard_sel     <= 1'b0;
      pcnt         <= '0;
      tcnt         <= '0;
      wd_cnt       <= '0;
      fail_cnt     <= '0;
      fault_flag   <= 1'b0;
      reset_reason <= 2'b00;
      cnt_soft     <= '0;
      cnt_hard     <= '0;
      cnt_wd       <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (trig) begin
            fail_cnt <= '0;
            wd_cnt   <= '0;
            if (lvl == 2'd2) begin
              fault_flag <= 1'b1;
            end else begin
              st           <= S_PULSE;
              hard_sel     <= (lvl == 2'd1);
              lvl          <= lvl + 2'd1;
              pcnt         <= pw_eff - PW_W'(1);
              reset_reason <= fail_hit ? WHY_FAIL : WHY_WDOG;
              if (lvl == 2'd1) begin
                if (cnt_hard != CNT_MAX) cnt_hard <= cnt_hard + CNT_W'(1);
              end else begin
                if (cnt_soft != CNT_MAX) cnt_soft <= cnt_soft + CNT_W'(1);
              end
              if (!fail_hit && cnt_wd != CNT_MAX) cnt_wd <= cnt_wd + CNT_W'(1);
            end
          end else begin
            if (ok_done) begin
              fail_cnt <= '0;
              lvl      <= 2'd0;
            end else if (bad_done && fail_cnt != FAIL_MAX) begin
              fail_cnt <= fail_cnt + FAIL_W'(1);
            end
            if (!wd_on || wd_act)       wd_cnt <= '0;
            else if (wd_cnt != TMR_MAX) wd_cnt <= wd_cnt + TMR_W'(1);
          end
        end
        S_PULSE: begin
          wd_cnt <= '0;
          if (pcnt == '0) begin
            if (cfg_settle_time == '0) begin
              st <= S_RUN;
            end else begin
              st   <= S_SETTLE;
              tcnt <= cfg_settle_time - TMR_W'(1);
            end
          end else begin
            pcnt <= pcnt - PW_W'(1);
          end
        end
        S_SETTLE: begin
          wd_cnt <= '0;
          if (tcnt == '0) st <= S_RUN;
          else            tcnt <= tcnt - TMR_W'(1);
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |=> fault_flag);

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_flag) |-> !detach_req);

  assert_hard_after_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_rst_req) |-> cnt_soft != '0);

  assert_soft_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(soft_rst_req) && $past(cnt_soft) != CNT_MAX) |-> cnt_soft == $past(cnt_soft) + CNT_W'(1));

  assert_hard_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hard_rst_req) && $past(cnt_hard) != CNT_MAX) |-> cnt_hard == $past(cnt_hard) + CNT_W'(1));

  assert_reason_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detach_req) |-> reset_reason != 2'b00);

  assert_window_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    detach_req |-> fail_run == '0);

endmodule

// File: tb/recovery_escalator_tb.sv
`timescale 1ns/1ps
module recovery_escalator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_done = 1'b0, txn_fail = 1'b0, wd_kick = 1'b0;
  logic [7:0]  cfg_fail_limit = 8'd3;
  logic [15:0] cfg_wd_timeout = 16'd0;
  logic [7:0]  cfg_pulse_width = 8'd4;
  logic [15:0] cfg_settle_time = 16'd6;
  logic        soft_rst_req, hard_rst_req, detach_req, fault_flag;
  logic [1:0]  reset_reason;
  logic [7:0]  fail_run, cnt_soft, cnt_hard, cnt_wd;

  int checks = 0;
  int errors = 0;

  typedef struct { int kind; int why; int width; int dlen; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  recovery_escalator u_dut (
    .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_fail(txn_fail),
    .wd_kick(wd_kick), .cfg_fail_limit(cfg_fail_limit),
    .cfg_wd_timeout(cfg_wd_timeout), .cfg_pulse_width(cfg_pulse_width),
    .cfg_settle_time(cfg_settle_time), .soft_rst_req(soft_rst_req),
    .hard_rst_req(hard_rst_req), .detach_req(detach_req),
    .fault_flag(fault_flag), .reset_reason(reset_reason), .fail_run(fail_run),
    .cnt_soft(cnt_soft), .cnt_hard(cnt_hard), .cnt_wd(cnt_wd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int kind, input int why);
    exp_t e;
    e.kind  = kind;
    e.why   = why;
    e.width = (cfg_pulse_width == 0) ? 1 : int'(cfg_pulse_width);
    e.dlen  = e.width + int'(cfg_settle_time);
    exp_q.push_back(e);
  endtask

  task automatic do_txn(input logic f);
    txn_done = 1'b1;
    txn_fail = f;
    @(negedge clk);
    txn_done = 1'b0;
    txn_fail = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int m_kind = 0, m_w = 0, m_d = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_w = 0; m_d = 0;
    end else begin
      if (soft_rst_req) begin m_kind = 1; m_w++; end
      if (hard_rst_req) begin m_kind = 2; m_w++; end
      if (detach_req) m_d++;
      else if (m_d != 0) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected recovery actual=%0d expected=0", m_kind);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R4 request kind", m_kind, e.kind);
          check("R5 pulse width", m_w, e.width);
          check("R6 detach length", m_d, e.dlen);
          check("R10 reason", int'(reset_reason), e.why);
        end
        m_kind = 0; m_w = 0; m_d = 0;
      end
    end
  end

  initial begin
    idle(3);
    check("R1 soft", soft_rst_req, 0);
    check("R1 hard", hard_rst_req, 0);
    check("R1 detach", detach_req, 0);
    check("R1 fault", fault_flag, 0);
    check("R1 reason", reset_reason, 0);
    check("R1 counts", fail_run + cnt_soft + cnt_hard + cnt_wd, 0);
    rst_n = 1'b1;
    idle(2);

    do_txn(1); do_txn(1);
    check("R12 run", fail_run, 2);
    check("R2 below limit", detach_req, 0);
    push_exp(1, 1);
    do_txn(1);
    check("R2 soft next cycle", soft_rst_req, 1);
    check("R6 detach with pulse", detach_req, 1);
    for (int i = 0; i < 5; i++) do_txn(1);
    idle(8);
    check("R7 run after window", fail_run, 0);
    check("R11 soft count", cnt_soft, 1);
    do_txn(1); do_txn(1);
    check("R7 window fails not counted", detach_req, 0);
    push_exp(2, 1);
    do_txn(1);
    check("R4 hard next cycle", hard_rst_req, 1);
    idle(12);
    check("R11 hard count", cnt_hard, 1);

    do_txn(1);
    do_txn(0);
    check("R3 success clears run", fail_run, 0);
    push_exp(1, 1);
    do_txn(1); do_txn(1); do_txn(1);
    check("R3 soft again", soft_rst_req, 1);
    idle(12);

    cfg_pulse_width = 8'd0;
    push_exp(2, 1);
    do_txn(1); do_txn(1); do_txn(1);
    check("R5 zero width acts as one", hard_rst_req, 1);
    idle(10);

    do_txn(1); do_txn(1); do_txn(1);
    check("R8 fault set", fault_flag, 1);
    check("R8 no detach", detach_req, 0);
    do_txn(0);
    for (int i = 0; i < 4; i++) do_txn(1);
    idle(10);
    check("R8 fault sticky", fault_flag, 1);
    check("R8 no further hard", cnt_hard, 2);
    check("R11 soft total", cnt_soft, 2);
    check("R10 reason held", reset_reason, 1);

    rst_n = 1'b0;
    idle(2);
    check("R1 fault cleared", fault_flag, 0);
    rst_n = 1'b1;
    cfg_pulse_width = 8'd3;
    idle(100);
    check("R9 disabled watchdog", cnt_wd, 0);
    cfg_wd_timeout = 16'd20;
    for (int i = 0; i < 6; i++) begin
      wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
      idle(9);
    end
    check("R9 kicks hold off", detach_req, 0);
    push_exp(1, 2);
    wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
    idle(19);
    check("R9 not before timeout", soft_rst_req, 0);
    idle(1);
    check("R9 fires at timeout", soft_rst_req, 1);
    cfg_wd_timeout = 16'd0;
    idle(12);
    check("R11 wd count", cnt_wd, 1);
    check("R10 watchdog reason", reset_reason, 2);
    check("R2 all recoveries seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule